// File: doc/BRIEF.md
# Grouped Interrupt Combiner

The combiner gathers level-sensitive interrupt sources into groups of eight and drives one level line per group toward a parent interrupt controller. Four groups share one 32-bit register window, and the number of windows is a parameter. Within a window, group `n` owns byte `n % 4` (bits `[8*(n%4)+7 : 8*(n%4)]`). Source number `s = group*8 + bit` therefore maps to window `s/32`, bit `s%32`.

Software uses the simple synchronous register bus to control the block. It sets enables by writing ones to one register and clears them by writing ones to another, so masking a source never needs a read-modify-write. A third register shows which enabled sources are asserted. Priority selection among pending sources is left to software, which reads that status word. Each source input passes through a two-flop synchronizer. A group line is asserted while any enabled source in its group is asserted.

Top module: `irq_group_combiner`

## Requirements
- R1: After reset, all enable bits are 0, every group line is 0 and the read data is 0, even while sources are asserted.
- R2: A write to window offset 0x0 sets every enable bit whose write-data bit is 1. Bits written as 0 keep their value.
- R3: A write to window offset 0x4 clears every enable bit whose write-data bit is 1. Bits written as 0 keep their value.
- R4: A read at offset 0x0 or 0x4 returns the window's current enable word. Read data is registered: it appears one cycle after the address and reflects state before any write made in that same cycle.
- R5: A read at offset 0xC returns, for each of the window's 32 bits, the synchronized source AND its enable bit. Bit b of window w belongs to source w*32+b.
- R6: Group line n is the OR of the eight status bits of group n, where group n is byte n%4 of window n/4.
- R7: Writes to offsets 0x8 and 0xC are ignored. Any access whose byte address bits [1:0] are not zero is ignored. Reads of 0x8 and of such unaligned addresses return 0.
- R8: A source change reaches the group line after exactly two rising clock edges. The status register shows it one edge later.
- R9: Window w sits at byte base w*0x10. A write affects only the addressed window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (5) | Byte address: [ADDR_W-1:4] window, [3:2] register, [1:0] must be 0 |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| src_in | input | N_WIN*32 (64) | Level interrupt sources, asynchronous |
| grp_irq | output | N_WIN*4 (8) | One level line per group |

## Verification
An enable write takes effect at the edge on which it is presented. The group lines follow combinationally from the new enables, so the bench checks them at the falling edge after the write. A source change needs two edges: the bench checks at the falling edge after the first edge that the line has not moved yet, and checks its new value after the second. Read data lags the address by one edge, so every read is sampled one falling edge after the address is set. The bench sweeps every single-source position and random combinations of enables and sources, and compares each result against a model built from the register rules.

// File: rtl/irq_cmb_pkg.sv
// Package: shared constants and register selector encoding for the combiner.
// Assumes 32-bit register windows holding four 8-source groups each.
package irq_cmb_pkg;
    localparam int WORD_W      = 32;
    localparam int GRP_SRC     = 8;
    localparam int GRP_PER_WIN = WORD_W / GRP_SRC;

    // Register selector taken from byte address bits [3:2]
    typedef enum logic [1:0] {
        SEL_EN_SET = 2'd0,
        SEL_EN_CLR = 2'd1,
        SEL_SPARE  = 2'd2,
        SEL_STATUS = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/cmb_sync.sv
// Module: cmb_sync
// Multi-stage flop synchronizer for a vector of asynchronous level inputs.
// Assumes each bit is a slow level; no bus coherence across bits is implied.
module cmb_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);
    logic [WIDTH-1:0] stg [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            // Purpose: shift the sample one stage further from the async domain
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= '0;
                else if (i == 0) stg[i] <= d_in;
                else stg[i] <= stg[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign q_out = stg[STAGES-1];
endmodule

// File: rtl/cmb_window.sv
// Module: cmb_window
// One register window: a 32-bit enable word with set/clear write ports,
// the gated status word and one OR line per 8-bit group.
// Assumes set_we and clr_we are never high together (decoded from one address).
module cmb_window
    import irq_cmb_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   set_we,
    input  logic                   clr_we,
    input  logic [WORD_W-1:0]      wdata,
    input  logic [WORD_W-1:0]      src_s,
    output logic [WORD_W-1:0]      en_q,
    output logic [WORD_W-1:0]      status,
    output logic [GRP_PER_WIN-1:0] grp_out
);
    // Purpose: hold enables, updated only through write-one set/clear
    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= '0;
        else if (set_we) en_q <= en_q | wdata;
        else if (clr_we) en_q <= en_q & ~wdata;
    end

    // Purpose: gate synchronized sources with their enables
    always_comb status = src_s & en_q;

    generate
        for (genvar g = 0; g < GRP_PER_WIN; g++) begin : g_grp
            assign grp_out[g] = |status[g*GRP_SRC +: GRP_SRC];
        end
    endgenerate
endmodule

// File: rtl/irq_group_combiner.sv
// Module: irq_group_combiner (top)
// Groups level interrupt sources by eight, N_WIN windows of four groups each.
// Address decode: [ADDR_W-1:4] window, [3:2] register, [1:0] must be zero.
// Assumes sources are levels held until serviced; read data is registered.
module irq_group_combiner
    import irq_cmb_pkg::*;
#(
    parameter int N_WIN       = 2,
    parameter int SYNC_STAGES = 2,
    localparam int WIN_BITS   = (N_WIN > 1) ? $clog2(N_WIN) : 1,
    localparam int ADDR_W     = WIN_BITS + 4,
    localparam int N_SRC      = N_WIN * WORD_W,
    localparam int N_GRP      = N_WIN * GRP_PER_WIN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic [N_SRC-1:0]  src_in,
    output logic [N_GRP-1:0]  grp_irq
);
    logic [WIN_BITS-1:0] win_sel;
    reg_sel_e            reg_sel;
    logic                aligned;
    logic [N_SRC-1:0]    src_s;
    logic [N_SRC-1:0]    en_all;
    logic [WORD_W-1:0]   en_word   [N_WIN];
    logic [WORD_W-1:0]   stat_word [N_WIN];
    logic [WORD_W-1:0]   rd_next;

    assign win_sel = bus_addr[ADDR_W-1:4];
    assign reg_sel = reg_sel_e'(bus_addr[3:2]);
    assign aligned = (bus_addr[1:0] == 2'b00);

    cmb_sync #(.WIDTH(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (src_in),
        .q_out (src_s)
    );

    generate
        for (genvar w = 0; w < N_WIN; w++) begin : g_win
            logic hit;
            assign hit = aligned && (win_sel == WIN_BITS'(w));

            cmb_window u_win (
                .clk     (clk),
                .rst_n   (rst_n),
                .set_we  (bus_we && hit && (reg_sel == SEL_EN_SET)),
                .clr_we  (bus_we && hit && (reg_sel == SEL_EN_CLR)),
                .wdata   (bus_wdata),
                .src_s   (src_s[w*WORD_W +: WORD_W]),
                .en_q    (en_word[w]),
                .status  (stat_word[w]),
                .grp_out (grp_irq[w*GRP_PER_WIN +: GRP_PER_WIN])
            );
            assign en_all[w*WORD_W +: WORD_W] = en_word[w];
        end
    endgenerate

    // Purpose: select read data for the addressed window and register
    always_comb begin
        rd_next = '0;
        for (int w = 0; w < N_WIN; w++) begin
            if (aligned && (win_sel == WIN_BITS'(w))) begin
                case (reg_sel)
                    SEL_EN_SET, SEL_EN_CLR: rd_next = en_word[w];
                    SEL_STATUS:             rd_next = stat_word[w];
                    default:                rd_next = '0;
                endcase
            end
        end
    end

    // Purpose: register read data one cycle after the address
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= rd_next;
    end
endmodule

// File: rtl/cmb_checker.sv
// Module: cmb_checker
// Temporal checks on the combiner ports and its enable state, bound to the top.
// Assumes the top's default decode: window in [ADDR_W-1:4], register in [3:2].
module cmb_checker #(
    parameter int N_WIN  = 2,
    parameter int ADDR_W = 5,
    localparam int WIN_BITS = ADDR_W - 4,
    localparam int N_SRC    = N_WIN * 32,
    localparam int N_GRP    = N_WIN * 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [N_SRC-1:0]  src_in,
    input logic [N_GRP-1:0]  grp_irq,
    input logic [N_SRC-1:0]  en_all
);
    logic [WIN_BITS-1:0] win;
    logic [1:0]          sel;
    logic                ok_addr;

    assign win     = bus_addr[ADDR_W-1:4];
    assign sel     = bus_addr[3:2];
    assign ok_addr = (bus_addr[1:0] == 2'b00) &&
                     ({1'b0, win} < (WIN_BITS+1)'(N_WIN));

    function automatic logic [31:0] word_of(input logic [N_SRC-1:0] v,
                                            input logic [WIN_BITS-1:0] w);
        return 32'(v >> {w, 5'b0});
    endfunction

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && ok_addr && sel == 2'd0) |=>
        ((word_of(en_all, $past(win)) & $past(bus_wdata)) == $past(bus_wdata))); // R2

    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && ok_addr && sel == 2'd1) |=>
        ((word_of(en_all, $past(win)) & $past(bus_wdata)) == 32'd0)); // R3

    AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we || !ok_addr || sel[1]) |=> $stable(en_all)); // R7

    AST_READ_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_addr && !sel[1]) |=> (bus_rdata == word_of($past(en_all), $past(win)))); // R4

    AST_QUIET_SOURCES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(src_in, 2) == '0) |-> (grp_irq == '0)); // R8

    generate
        for (genvar g = 0; g < N_GRP; g++) begin : g_chk
            AST_GROUP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
                grp_irq[g] |-> (|en_all[g*8 +: 8])); // R6
        end
    endgenerate
endmodule

bind irq_group_combiner cmb_checker #(.N_WIN(N_WIN), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .src_in    (src_in),
    .grp_irq   (grp_irq),
    .en_all    (en_all)
);

// File: tb/irq_group_combiner_tb.sv
// Bench: sweeps every source position and random enable/source mixes on a
// two-window combiner, with expectations computed from the register rules.
module irq_group_combiner_tb;
    localparam int NW = 2;
    localparam int NS = NW * 32;
    localparam int NG = NW * 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NS-1:0] src_in = '0;
    logic [NG-1:0] grp_irq;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] m_en [NW];

    always #4 clk = ~clk;   // 125 MHz

    irq_group_combiner #(.N_WIN(NW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_in(src_in), .grp_irq(grp_irq)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        if (a[1:0] == 2'b00 && a[3:2] == 2'd0) m_en[a[4]] = m_en[a[4]] | d;
        if (a[1:0] == 2'b00 && a[3:2] == 2'd1) m_en[a[4]] = m_en[a[4]] & ~d;
    endtask

    task automatic do_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        @(negedge clk);
        d = bus_rdata;
    endtask

    function automatic logic [NG-1:0] exp_grp(input logic [NS-1:0] s);
        logic [NG-1:0] r;
        logic [NS-1:0] st;
        st = s & {m_en[1], m_en[0]};
        for (int g = 0; g < NG; g++) r[g] = |st[g*8 +: 8];
        return r;
    endfunction

    task automatic check_enables(input string tag);
        logic [31:0] v;
        for (int w = 0; w < NW; w++) begin
            do_read({w[0], 4'h0}, v);
            chk({tag, " rd0x0"}, 64'(v), 64'(m_en[w]));
            do_read({w[0], 4'h4}, v);
            chk({tag, " rd0x4"}, 64'(v), 64'(m_en[w]));
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1..all act=timeout exp=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        m_en[0] = '0; m_en[1] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, sources asserted but nothing enabled
        chk("R1 grp after reset", 64'(grp_irq), 64'd0);
        chk("R1 rdata after reset", 64'(bus_rdata), 64'd0);
        src_in = '1;
        repeat (3) @(negedge clk);
        chk("R1 grp with sources, no enables", 64'(grp_irq), 64'd0);
        check_enables("R1");
        do_read(5'h0C, v);
        chk("R1 status w0", 64'(v), 64'd0);
        src_in = '0;
        repeat (3) @(negedge clk);

        // R2/R3/R9: set and clear patterns per window, other window untouched
        do_write(5'h00, 32'hA5A5_0F0F);
        check_enables("R2 set w0 R9");
        do_write(5'h10, 32'h1234_5678);
        do_write(5'h00, 32'h0000_F000);
        check_enables("R2 set merge R9");
        do_write(5'h04, 32'h8000_0F01);
        check_enables("R3 clear w0");
        do_write(5'h14, 32'hFFFF_0000);
        check_enables("R3 clear w1 R9");

        // R7: ignored writes and zero reads
        do_write(5'h08, 32'hFFFF_FFFF);
        do_write(5'h0C, 32'hFFFF_FFFF);
        do_write(5'h01, 32'hFFFF_FFFF);
        do_write(5'h15, 32'hFFFF_FFFF);
        check_enables("R7 ignored writes");
        do_read(5'h08, v);
        chk("R7 read spare", 64'(v), 64'd0);
        do_read(5'h02, v);
        chk("R7 read unaligned", 64'(v), 64'd0);

        // R4: same-cycle write returns old value
        @(negedge clk);
        bus_addr = 5'h10; bus_wdata = 32'hFFFF_FFFF; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        chk("R4 read old on write", 64'(bus_rdata), 64'(m_en[1]));
        m_en[1] = 32'hFFFF_FFFF;

        // R5/R6/R8: sweep every single source
        for (int s = 0; s < NS; s++) begin
            do_write(5'h00, 32'hFFFF_FFFF);
            do_write(5'h10, 32'hFFFF_FFFF);
            @(negedge clk);
            src_in = NS'(1) << s;
            @(negedge clk);
            chk($sformatf("R8 src %0d one edge", s), 64'(grp_irq), 64'd0);
            @(negedge clk);
            chk($sformatf("R6 R8 src %0d grp", s), 64'(grp_irq), 64'(NG'(1) << (s / 8)));
            do_read({s[5], 4'hC}, v);
            chk($sformatf("R5 src %0d status", s), 64'(v), 64'(32'(1) << (s % 32)));
            do_read({~s[5], 4'hC}, v);
            chk($sformatf("R5 R9 src %0d other status", s), 64'(v), 64'd0);
            do_write({s[5], 4'h4}, 32'(1) << (s % 32));
            chk($sformatf("R3 R6 src %0d masked", s), 64'(grp_irq), 64'd0);
            @(negedge clk);
            src_in = '0;
            @(negedge clk);
        end

        // R5/R6: random enable and source mixes
        for (int it = 0; it < 40; it++) begin
            logic [NS-1:0] s;
            logic [31:0] e0, e1;
            e0 = $urandom; e1 = $urandom;
            if (it % 4 == 0) e0 = e0 & 32'h00FF_00FF;
            s = {$urandom, $urandom};
            do_write(5'h04, 32'hFFFF_FFFF);
            do_write(5'h14, 32'hFFFF_FFFF);
            do_write(5'h00, e0);
            do_write(5'h10, e1);
            @(negedge clk);
            src_in = s;
            repeat (2) @(negedge clk);
            chk($sformatf("R6 mix %0d grp", it), 64'(grp_irq), 64'(exp_grp(s)));
            do_read(5'h0C, v);
            chk($sformatf("R5 mix %0d status w0", it), 64'(v), 64'(s[31:0] & m_en[0]));
            do_read(5'h1C, v);
            chk($sformatf("R5 mix %0d status w1", it), 64'(v), 64'(s[63:32] & m_en[1]));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule